// File: doc/BRIEF.md
# Sliding-Window Jet Finder

The block receives, once per bunch crossing, a tile of calorimeter tower energies arranged as 20 bins along eta by 16 bins along phi. Every bin carries an electromagnetic and a hadronic energy of up to 16 bits each. The block adds the two layers per bin. It then forms a 9×9 window sum centred on each of the 12×8 core bins, using the 4-bin halo that surrounds the core. It flags a core bin as a jet candidate when its window sum is a local maximum among the core window sums and lies above a programmable threshold.

The block takes a new tile on every clock in which `in_valid` is high, with no stall. The per-bin sum, the eta partial sums, the phi sums and the candidate decision each sit in their own register stage. Results leave on a fixed-latency strobe. The threshold is written through a small write port that is honoured only while the pipeline holds no tile.

Top module: `jet_window_finder`

## Requirements
- R1: The energy of a bin is the full 17-bit sum of its electromagnetic and hadronic values, with no truncation. With both inputs at 0xFFFF in every bin, each window sum equals 81 × 131070.
- R2: For core bin (ce, cp), with ce in 0..11 and cp in 0..7, the window sum is the sum of the bin energies at eta ce..ce+8 and phi cp..cp+8. It is reported on `win_sum[i*24 +: 24]`, where i = cp*12 + ce. Input bin (eta e, phi p) sits at `em_in/had_in[(p*20+e)*16 +: 16]`.
- R3: `out_valid` goes high exactly 4 clock edges after the edge that samples `in_valid` high, for one cycle per tile. Tiles presented on consecutive cycles each produce their own result on consecutive cycles.
- R4: `cand_mask[i]` requires window sum i to be greater than or equal to the sums of its core neighbours that come earlier in the order (cp, then ce), and strictly greater than the sums of later core neighbours. Neighbours outside the core are not compared. Two equal adjacent windows therefore never both fire.
- R5: `cand_mask[i]` additionally requires window sum i to be strictly greater than the threshold. A sum equal to the threshold is not a candidate.
- R6: A threshold write (`thr_we` with `thr_in`) takes effect only when `in_valid` is low and no tile is in flight. A write issued while the pipeline is busy is ignored.
- R7: Reset forces `out_valid` low and sets the threshold to 0. No result appears until a tile has passed through all stages.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| thr_we | input | 1 | Threshold write strobe |
| thr_in | input | 24 | Threshold value to write |
| in_valid | input | 1 | Tile present on em_in/had_in |
| em_in | input | 5120 | 320 electromagnetic energies, 16 bits each |
| had_in | input | 5120 | 320 hadronic energies, 16 bits each |
| out_valid | output | 1 | Result strobe |
| cand_mask | output | 96 | Candidate flag per core bin |
| win_sum | output | 2304 | 24-bit window sum per core bin |

## Verification
A threshold write and a tile in flight can fall in the same cycle. The bench provokes this by raising `thr_we` on the same clock as `in_valid`. It then judges the outcome from a later tile whose peak lies between the old and the new threshold, and expects the old value to be kept. A second overlap is a tile entering while earlier tiles are still in the pipeline. Back-to-back tiles are pushed into a scoreboard, and each result is checked against its own expected sums, mask and arrival cycle.

// File: rtl/jet_window_finder.sv
module jet_window_finder #(
  parameter int EW = 16,
  parameter int ETA_CORE = 12,
  parameter int PHI_CORE = 8,
  parameter int HALO = 4,
  parameter int SW = 24
) (
  input  logic clk,
  input  logic rst_n,
  input  logic thr_we,
  input  logic [SW-1:0] thr_in,
  input  logic in_valid,
  input  logic [(ETA_CORE+2*HALO)*(PHI_CORE+2*HALO)*EW-1:0] em_in,
  input  logic [(ETA_CORE+2*HALO)*(PHI_CORE+2*HALO)*EW-1:0] had_in,
  output logic out_valid,
  output logic [ETA_CORE*PHI_CORE-1:0] cand_mask,
  output logic [ETA_CORE*PHI_CORE*SW-1:0] win_sum
);
  localparam int NETA = ETA_CORE + 2*HALO;
  localparam int NPHI = PHI_CORE + 2*HALO;
  localparam int WIN = 2*HALO + 1;
  localparam int BW = EW + 1;
  localparam int PW = BW + $clog2(WIN);
  localparam int WW = PW + $clog2(WIN);
  localparam int NCORE = ETA_CORE*PHI_CORE;

  logic [3:0] vld;
  logic [SW-1:0] thr_q;
  logic [BW-1:0] bin_q [NPHI][NETA];
  logic [PW-1:0] row_d [NPHI][ETA_CORE];
  logic [PW-1:0] row_q [NPHI][ETA_CORE];
  logic [WW-1:0] win_d [PHI_CORE][ETA_CORE];
  logic [SW-1:0] win_q [PHI_CORE][ETA_CORE];
  logic [NCORE-1:0] cand_d;

  assign out_valid = vld[3];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld <= '0;
      thr_q <= '0;
    end else begin
      vld <= {vld[2:0], in_valid};
      if (thr_we && !in_valid && vld == '0) thr_q <= thr_in;
    end
  end

  for (genvar p = 0; p < NPHI; p++) begin : g_phi
    for (genvar e = 0; e < NETA; e++) begin : g_eta
      always_ff @(posedge clk)
        bin_q[p][e] <= BW'(em_in[(p*NETA+e)*EW +: EW]) + BW'(had_in[(p*NETA+e)*EW +: EW]);
    end
  end

  always_comb begin
    for (int p = 0; p < NPHI; p++)
      for (int c = 0; c < ETA_CORE; c++) begin
        row_d[p][c] = '0;
        for (int k = 0; k < WIN; k++) row_d[p][c] = row_d[p][c] + PW'(bin_q[p][c+k]);
      end
  end

  always_comb begin
    for (int p = 0; p < PHI_CORE; p++)
      for (int c = 0; c < ETA_CORE; c++) begin
        win_d[p][c] = '0;
        for (int k = 0; k < WIN; k++) win_d[p][c] = win_d[p][c] + WW'(row_q[p+k][c]);
      end
  end

  function automatic logic [SW-1:0] clamp(input logic [WW-1:0] v);
    return (v > WW'({SW{1'b1}})) ? {SW{1'b1}} : v[SW-1:0];
  endfunction

  always_ff @(posedge clk) begin
    row_q <= row_d;
    for (int p = 0; p < PHI_CORE; p++)
      for (int c = 0; c < ETA_CORE; c++) win_q[p][c] <= clamp(win_d[p][c]);
  end

  always_comb begin
    for (int p = 0; p < PHI_CORE; p++)
      for (int c = 0; c < ETA_CORE; c++) begin
        cand_d[p*ETA_CORE+c] = win_q[p][c] > thr_q;
        for (int dp = -1; dp <= 1; dp++)
          for (int dc = -1; dc <= 1; dc++) begin
            int np;
            int nc;
            np = p + dp;
            nc = c + dc;
            if (!(dp == 0 && dc == 0) && np >= 0 && np < PHI_CORE && nc >= 0 && nc < ETA_CORE) begin
              if (dp < 0 || (dp == 0 && dc < 0))
                cand_d[p*ETA_CORE+c] = cand_d[p*ETA_CORE+c] & (win_q[p][c] >= win_q[np][nc]);
              else
                cand_d[p*ETA_CORE+c] = cand_d[p*ETA_CORE+c] & (win_q[p][c] > win_q[np][nc]);
            end
          end
      end
  end

  always_ff @(posedge clk) begin
    cand_mask <= cand_d;
    for (int p = 0; p < PHI_CORE; p++)
      for (int c = 0; c < ETA_CORE; c++) win_sum[(p*ETA_CORE+c)*SW +: SW] <= win_q[p][c];
  end
endmodule

module jet_window_finder_chk #(
  parameter int ETA_CORE = 12,
  parameter int PHI_CORE = 8,
  parameter int SW = 24
) (
  input logic clk,
  input logic rst_n,
  input logic thr_we,
  input logic in_valid,
  input logic [3:0] vld,
  input logic [SW-1:0] thr_q,
  input logic out_valid,
  input logic [ETA_CORE*PHI_CORE-1:0] cand_mask,
  input logic [ETA_CORE*PHI_CORE*SW-1:0] win_sum
);
  function automatic logic all_above(input logic [ETA_CORE*PHI_CORE-1:0] m,
                                     input logic [ETA_CORE*PHI_CORE*SW-1:0] s,
                                     input logic [SW-1:0] t);
    for (int i = 0; i < ETA_CORE*PHI_CORE; i++)
      if (m[i] && !(s[i*SW +: SW] > t)) return 1'b0;
    return 1'b1;
  endfunction

  function automatic logic no_twin(input logic [ETA_CORE*PHI_CORE-1:0] m,
                                   input logic [ETA_CORE*PHI_CORE*SW-1:0] s);
    for (int p = 0; p < PHI_CORE; p++)
      for (int c = 0; c < ETA_CORE; c++) begin
        int i;
        i = p*ETA_CORE + c;
        if (c+1 < ETA_CORE && m[i] && m[i+1] && s[i*SW +: SW] == s[(i+1)*SW +: SW]) return 1'b0;
        if (p+1 < PHI_CORE && m[i] && m[i+ETA_CORE] && s[i*SW +: SW] == s[(i+ETA_CORE)*SW +: SW]) return 1'b0;
      end
    return 1'b1;
  endfunction

  // R3
  lat_origin_chk: assert property (@(posedge clk) disable iff (!rst_n) out_valid |-> $past(in_valid, 4));
  // R3
  lat_arrive_chk: assert property (@(posedge clk) disable iff (!rst_n) in_valid |-> ##4 out_valid);
  // R4
  tie_break_chk: assert property (@(posedge clk) disable iff (!rst_n) out_valid |-> no_twin(cand_mask, win_sum));
  // R5
  thr_gate_chk: assert property (@(posedge clk) disable iff (!rst_n) out_valid |-> all_above(cand_mask, win_sum, thr_q));
  // R6
  thr_busy_chk: assert property (@(posedge clk) disable iff (!rst_n) (thr_we && (in_valid || vld != 4'd0)) |=> $stable(thr_q));
  // R6
  thr_idle_chk: assert property (@(posedge clk) disable iff (!rst_n) !thr_we |=> $stable(thr_q));
  // R7
  rst_quiet_chk: assert property (@(posedge clk) !rst_n |=> !out_valid);
endmodule

bind jet_window_finder jet_window_finder_chk #(.ETA_CORE(ETA_CORE), .PHI_CORE(PHI_CORE), .SW(SW)) u_chk (
  .clk(clk), .rst_n(rst_n), .thr_we(thr_we), .in_valid(in_valid), .vld(vld), .thr_q(thr_q),
  .out_valid(out_valid), .cand_mask(cand_mask), .win_sum(win_sum)
);

// File: tb/jet_window_finder_bench.sv
module jet_window_finder_bench;
  localparam int NE = 20, NP = 16, CE = 12, CP = 8, NC = 96;

  logic clk = 0, rst_n = 0, thr_we = 0, in_valid = 0;
  logic [23:0] thr_in = '0;
  logic [NE*NP*16-1:0] em_in = '0, had_in = '0;
  logic out_valid;
  logic [NC-1:0] cand_mask;
  logic [NC*24-1:0] win_sum;

  jet_window_finder u_jet_window_finder (.*);

  always #4 clk = ~clk;

  int errors = 0, checks = 0, cyc = 0;
  int unsigned em_a [NP][NE];
  int unsigned had_a [NP][NE];
  int unsigned model_thr = 0;
  logic [NC-1:0] exp_mask_q [$];
  logic [NC*24-1:0] exp_sum_q [$];
  int exp_cyc_q [$];
  string tag_q [$];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input logic ok, input string req, input string what);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s", req, what);
    end
  endtask

  task automatic clear_tile();
    for (int p = 0; p < NP; p++)
      for (int e = 0; e < NE; e++) begin em_a[p][e] = 0; had_a[p][e] = 0; end
  endtask

  task automatic send(input string tag);
    int unsigned w [CP][CE];
    logic [NC-1:0] m;
    logic [NC*24-1:0] s;
    for (int p = 0; p < NP; p++)
      for (int e = 0; e < NE; e++) begin
        em_in[(p*NE+e)*16 +: 16] = 16'(em_a[p][e]);
        had_in[(p*NE+e)*16 +: 16] = 16'(had_a[p][e]);
      end
    for (int p = 0; p < CP; p++)
      for (int c = 0; c < CE; c++) begin
        w[p][c] = 0;
        for (int a = 0; a < 9; a++)
          for (int b = 0; b < 9; b++) w[p][c] += em_a[p+a][c+b] + had_a[p+a][c+b];
        s[(p*CE+c)*24 +: 24] = 24'(w[p][c]);
      end
    for (int p = 0; p < CP; p++)
      for (int c = 0; c < CE; c++) begin
        m[p*CE+c] = w[p][c] > model_thr;
        for (int dp = -1; dp <= 1; dp++)
          for (int dc = -1; dc <= 1; dc++)
            if (!(dp == 0 && dc == 0) && p+dp >= 0 && p+dp < CP && c+dc >= 0 && c+dc < CE) begin
              if (dp < 0 || (dp == 0 && dc < 0)) m[p*CE+c] &= w[p][c] >= w[p+dp][c+dc];
              else m[p*CE+c] &= w[p][c] > w[p+dp][c+dc];
            end
      end
    exp_mask_q.push_back(m);
    exp_sum_q.push_back(s);
    exp_cyc_q.push_back(cyc + 4);
    tag_q.push_back(tag);
    in_valid = 1;
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    in_valid = 0;
    repeat (n) @(negedge clk);
  endtask

  task automatic write_thr(input int unsigned v);
    thr_we = 1; thr_in = 24'(v); model_thr = v;
    @(negedge clk);
    thr_we = 0;
  endtask

  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      if (exp_mask_q.size() == 0) begin
        check(1'b0, "R3", "result with no tile pending: actual out_valid=1 expected 0");
      end else begin
        logic [NC-1:0] em;
        logic [NC*24-1:0] es;
        int ec;
        string t;
        em = exp_mask_q.pop_front(); es = exp_sum_q.pop_front();
        ec = exp_cyc_q.pop_front(); t = tag_q.pop_front();
        check(cyc == ec, "R3", $sformatf("arrival cycle actual=%0d expected=%0d", cyc, ec));
        check(win_sum == es, "R2", $sformatf("window sums (%s) actual bin0=%0d expected bin0=%0d", t, win_sum[23:0], es[23:0]));
        check(cand_mask == em, t, $sformatf("candidate mask actual=%h expected=%h", cand_mask, em));
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0, "R7", $sformatf("out_valid in reset actual=%b expected=0", out_valid));
    rst_n = 1;
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0, "R7", $sformatf("out_valid after reset actual=%b expected=0", out_valid));

    // R7: threshold is 0 after reset, a lone small bin must still fire
    clear_tile(); em_a[8][10] = 100; send("R7"); idle(6);

    // R1: every input at full scale
    for (int p = 0; p < NP; p++)
      for (int e = 0; e < NE; e++) begin em_a[p][e] = 16'hFFFF; had_a[p][e] = 16'hFFFF; end
    send("R1"); idle(6);

    // R2 and R3: three random tiles on consecutive cycles, halo corners hot
    for (int t = 0; t < 3; t++) begin
      for (int p = 0; p < NP; p++)
        for (int e = 0; e < NE; e++) begin em_a[p][e] = $urandom_range(0, 4095); had_a[p][e] = $urandom_range(0, 4095); end
      em_a[0][0] = 65535; had_a[NP-1][NE-1] = 65535;
      send(t == 1 ? "R3" : "R2");
    end
    idle(6);

    // R4: two equal peaks side by side and one diagonal pair
    clear_tile();
    em_a[6][8] = 900; em_a[6][9] = 900;
    had_a[11][14] = 700; had_a[12][15] = 700;
    send("R4"); idle(6);

    // R5: threshold equal to the peak, then one below it
    clear_tile(); em_a[9][12] = 500;
    write_thr(500); idle(2);
    send("R5"); idle(6);
    write_thr(499); idle(2);
    send("R5"); idle(6);

    // R6: write issued together with a tile is ignored (threshold stays 499)
    clear_tile(); em_a[9][12] = 450;
    thr_we = 1; thr_in = 24'd0;
    send("R6");
    thr_we = 0;
    idle(6);
    send("R6"); idle(6);
    // R6: the same write while idle takes effect
    write_thr(0); idle(2);
    send("R6"); idle(6);

    check(exp_mask_q.size() == 0, "R3", $sformatf("pending results actual=%0d expected=0", exp_mask_q.size()));
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule